// File: doc/BRIEF.md
# Buffered SPI Master with Register Window

This block is a bus-attached SPI master. Software writes bytes into a transmit queue through a data register. A shift engine takes each queued byte and exchanges it full duplex with the attached device. Every received byte goes into a receive queue, and software reads it back through the same data register. The control word carries the run bit, the interrupt enables and two self-clearing flush bits. Its upper bits give a live view of queue state. That view shows room in the transmit queue, data or a full receive queue, a three-quarter receive watermark, and completion.

One level-sensitive interrupt line combines the completion and watermark conditions, each under its own enable. Four more registers sit in the window: a clock divider, a length word, a 4-bit hold word and a 32-bit DMA-control word. The block only stores the length, hold and DMA-control words; the divider sets the serial clock rate.

The serial side runs in mode 0 and sends MSB first. Chip select is low for as long as the run bit is set. The engine never starts a byte while the receive queue is full, so no received data is lost.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset both queues are empty. The control word reads 0x120 (read-enable bit 5 and TXD bit 8 set). The divider and length read 0, the hold word reads 1, the DMA-control word reads 0x30201020, irq_o is 0, csn_o is 1 and sclk_o is 0.
- R2: Control word layout at offset 0x00:
  - writable bits: run bit 0, DONE-interrupt enable bit 3, watermark-interrupt enable bit 4, read-enable bit 5;
  - status bits 12:8 (DONE 12, RXR 11, RXF 10, RXD 9, TXD 8) ignore writes;
  - bit 1 flushes the receive queue and bit 2 flushes the transmit queue; both act at once and read back 0.
- R3: TXD is 1 while the transmit queue is not full. A write to the data register (0x04) queues bits 7:0 only when the run bit is 1 and TXD is 1. Otherwise the write has no effect.
- R4: DONE is 1 exactly when the run bit is 1 and the transmit queue is empty.
- R5: RXD is 1 while the receive queue holds a byte. RXF is 1 when the receive queue is full. RXR is 1 when the run bit is 1 and receive occupancy is at least three quarters of the depth (12 of 16).
- R6: irq_o is high exactly when (bit 3 and DONE) or (bit 4 and RXR).
- R7: Each queued byte is sent on mosi_o MSB first, in mode 0 (data changes while sclk_o is low, miso_i is sampled on the rising edge). The byte sampled from miso_i is queued for reception in send order. Clearing the run bit aborts a byte in flight, and that byte is not received. csn_o is low while the run bit is 1.
- R8: No byte starts while the receive queue is full. Bytes wait in the transmit queue until a read frees a slot.
- R9: A data-register read returns and removes the oldest received byte when RXD is 1. Otherwise it returns 0 and changes nothing.
- R10: The divider (0x08) and length (0x0C) keep 16 bits, the hold word (0x10) keeps 4 bits and the DMA-control word (0x14) keeps 32 bits. Offsets 0x18 and 0x1C read 0 and ignore writes.
- R11: The sclk_o half period is max(1, divider/2) system cycles. A divider of 0 selects a half period of 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | byte offset of the register |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, valid in the access cycle |
| irq_o | output | 1 | level interrupt |
| sclk_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| miso_i | input | 1 | serial data in |
| csn_o | output | 1 | chip select, active low |

## Verification
Two activities can hit the receive queue in the same cycle: a software read pops the head while the shift engine pushes a newly finished byte. The same overlap can happen on the transmit side, where a data-register write lands in the cycle the engine takes the next byte. The bench provokes both. It reads the data register on every cycle during a loopback stream and drops extra writes in mid-stream. Every byte is nonzero, so a returned 0 always means the queue was empty. Each nonzero byte must match the head of the scoreboard queue, and the queue must be empty at the end, so a lost, doubled or reordered byte is caught.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int AW = 5;
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_DATA = 3'd1;
  localparam logic [2:0] IDX_DIV  = 3'd2;
  localparam logic [2:0] IDX_LEN  = 3'd3;
  localparam logic [2:0] IDX_HOLD = 3'd4;
  localparam logic [2:0] IDX_DMA  = 3'd5;

  localparam int B_RUN   = 0;
  localparam int B_CLRRX = 1;
  localparam int B_CLRTX = 2;
  localparam int B_IED   = 3;
  localparam int B_IER   = 4;
  localparam int B_REN   = 5;

  localparam logic [31:0] DMA_RST = 32'h3020_1020;
  localparam logic [15:0] HALF_MAX = 16'h8000;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign data_o  = mem_q[rptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> !full_o);
  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i) |-> !empty_o);
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_ready_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  eng_state_e state_q;
  logic [7:0] tsr_q, rsr_q;
  logic [2:0] bit_q;
  logic [DIV_W-1:0] hcnt_q, half;
  logic sclk_q, tick;

  always_comb begin
    if (div_i == '0)               half = DIV_W'(HALF_MAX);
    else if ((div_i >> 1) == '0)   half = DIV_W'(1);
    else                           half = div_i >> 1;
  end

  assign tick      = (state_q == ENG_SHIFT) && (hcnt_q == half - DIV_W'(1));
  assign tx_pop_o  = en_i && (state_q == ENG_IDLE) && tx_valid_i && rx_ready_i;
  assign rx_push_o = en_i && tick && sclk_q && (bit_q == 3'd7);
  assign rx_data_o = rsr_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tsr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      tsr_q   <= '0;
      rsr_q   <= '0;
      bit_q   <= '0;
      hcnt_q  <= '0;
      sclk_q  <= 1'b0;
    end else if (!en_i) begin
      state_q <= ENG_IDLE;
      hcnt_q  <= '0;
      sclk_q  <= 1'b0;
    end else if (state_q == ENG_IDLE) begin
      if (tx_pop_o) begin
        tsr_q   <= tx_data_i;
        bit_q   <= '0;
        hcnt_q  <= '0;
        state_q <= ENG_SHIFT;
      end
    end else if (!tick) begin
      hcnt_q <= hcnt_q + DIV_W'(1);
    end else begin
      hcnt_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rsr_q  <= {rsr_q[6:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == 3'd7) begin
          state_q <= ENG_IDLE;
        end else begin
          tsr_q <= {tsr_q[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
        end
      end
    end
  end

  // R7
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_IDLE) |-> !sclk_q);
  // R7
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(tsr_q[7]));
  // R11
  half_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_SHIFT) |-> (hcnt_q < half));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          csn_o
);
  logic run_q, ied_q, ier_q, ren_q;
  logic [15:0] div_q, len_q;
  logic [3:0]  hold_q;
  logic [31:0] dma_q;

  logic [2:0] idx;
  logic wr, rd, wr_ctrl, wr_data, rd_data;
  logic clr_rx, clr_tx;
  logic tx_push, tx_pop, tx_full, tx_empty;
  logic rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0] tx_head, rx_head, rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic txd, rxd, rxf, rxr, done;
  logic [31:0] ctrl_rd;

  assign idx     = addr_i[4:2];
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wr_ctrl = wr && (idx == IDX_CTRL);
  assign wr_data = wr && (idx == IDX_DATA);
  assign rd_data = rd && (idx == IDX_DATA);
  assign clr_rx  = wr_ctrl && wdata_i[B_CLRRX];
  assign clr_tx  = wr_ctrl && wdata_i[B_CLRTX];

  assign txd  = !tx_full;
  assign rxd  = !rx_empty;
  assign rxf  = rx_full;
  assign rxr  = run_q && (int'(rx_cnt) * 4 >= 3 * FIFO_DEPTH);
  assign done = run_q && tx_empty;

  assign tx_push = wr_data && run_q && txd;
  assign rx_pop  = rd_data && rxd;

  assign ctrl_rd = {19'b0, done, rxr, rxf, rxd, txd, 2'b0,
                    ren_q, ier_q, ied_q, 2'b0, run_q};
  assign irq_o = (ied_q && done) || (ier_q && rxr);
  assign csn_o = !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ied_q  <= 1'b0;
      ier_q  <= 1'b0;
      ren_q  <= 1'b1;
      div_q  <= '0;
      len_q  <= '0;
      hold_q <= 4'd1;
      dma_q  <= DMA_RST;
    end else if (wr) begin
      case (idx)
        IDX_CTRL: begin
          run_q <= wdata_i[B_RUN];
          ied_q <= wdata_i[B_IED];
          ier_q <= wdata_i[B_IER];
          ren_q <= wdata_i[B_REN];
        end
        IDX_DIV:  div_q  <= wdata_i[15:0];
        IDX_LEN:  len_q  <= wdata_i[15:0];
        IDX_HOLD: hold_q <= wdata_i[3:0];
        IDX_DMA:  dma_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (idx)
        IDX_CTRL: rdata_o = ctrl_rd;
        IDX_DATA: rdata_o = rxd ? {24'b0, rx_head} : '0;
        IDX_DIV:  rdata_o = {16'b0, div_q};
        IDX_LEN:  rdata_o = {16'b0, len_q};
        IDX_HOLD: rdata_o = {28'b0, hold_q};
        IDX_DMA:  rdata_o = dma_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk_i, .rst_ni, .clr_i(clr_tx), .push_i(tx_push), .data_i(wdata_i[7:0]),
    .pop_i(tx_pop), .data_o(tx_head), .cnt_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk_i, .rst_ni, .clr_i(clr_rx), .push_i(rx_push), .data_i(rx_byte),
    .pop_i(rx_pop), .data_o(rx_head), .cnt_o(rx_cnt), .full_o(rx_full),
    .empty_o(rx_empty));

  spi_shift_eng #(.DIV_W(16)) u_eng (
    .clk_i, .rst_ni, .en_i(run_q), .div_i(div_q),
    .tx_valid_i(!tx_empty), .tx_data_i(tx_head), .rx_ready_i(!rx_full),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_byte),
    .sclk_o, .mosi_o, .miso_i);

  // R6
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !irq_o);
  // R3
  ignore_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !run_q) |=> (tx_cnt == $past(tx_cnt)));
  // R8
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> !rx_full);
  // R7
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_o |=> !rx_push);
endmodule

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, sclk, mosi, csn;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];

  localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_DIV = 5'h08,
                         A_LEN = 5'h0C, A_HOLD = 5'h10, A_DMA = 5'h14;
  localparam logic [31:0] RUN = 32'h1, CLRRX = 32'h2, CLRTX = 32'h4,
                          IED = 32'h8, IER = 32'h10, REN = 32'h20;

  always #2 clk = ~clk;

  spi_fifo_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(mosi), .csn_o(csn));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: queue expectation, then write the byte
  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(A_DATA, {24'h0, b});
  endtask

  // monitor side: compare a returned byte with the queue head
  task automatic take(input string tag);
    logic [31:0] v;
    logic [7:0] e;
    rd(A_DATA, v);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
    chk(v == {24'h0, e}, tag, v, {24'h0, e});
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    longint t0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(irq == 1'b0 && csn == 1'b1 && sclk == 1'b0, "R1 pins", {irq, csn, sclk}, 3'b010);
    rd_chk(A_CTRL, 32'h120, "R1 ctrl");
    rd_chk(A_DIV, 32'h0, "R1 div");
    rd_chk(A_LEN, 32'h0, "R1 len");
    rd_chk(A_HOLD, 32'h1, "R1 hold");
    rd_chk(A_DMA, 32'h3020_1020, "R1 dma");

    // R10 storage widths, unmapped
    wr(A_DIV, 32'hABCD_1234);  rd_chk(A_DIV, 32'h1234, "R10 div");
    wr(A_LEN, 32'hFFFF_5555);  rd_chk(A_LEN, 32'h5555, "R10 len");
    wr(A_HOLD, 32'h37);        rd_chk(A_HOLD, 32'h7, "R10 hold");
    wr(A_DMA, 32'hDEAD_BEEF);  rd_chk(A_DMA, 32'hDEAD_BEEF, "R10 dma");
    wr(5'h18, 32'hFFFF_FFFF);  rd_chk(5'h18, 32'h0, "R10 unmapped");
    wr(A_DIV, 32'd4);

    // R3 data write ignored while idle
    wr(A_DATA, 32'h55);
    idle(60);
    rd_chk(A_CTRL, 32'h120, "R3 idle write ignored");
    wr(A_CTRL, RUN | REN);
    idle(60);
    rd_chk(A_DATA, 32'h0, "R9 empty read");
    chk(sclk == 1'b0, "R3 no shift", sclk, 0);

    // R2/R4/R6 status bits read-only, done, irq
    wr(A_CTRL, 32'h1F00 | RUN | IED | REN);
    rd_chk(A_CTRL, 32'h1129, "R2 R4 ctrl");
    chk(irq == 1'b1, "R6 done irq", irq, 1);
    chk(csn == 1'b0, "R7 csn active", csn, 0);
    wr(A_CTRL, RUN | REN);
    chk(irq == 1'b0, "R6 irq masked", irq, 0);

    // R7/R11 order, MSB first, sclk period
    send(8'hA5);
    @(posedge sclk); #1;
    chk(mosi == 1'b1, "R7 msb first", mosi, 1);
    t0 = $time;
    @(posedge sclk); #1;
    chk(mosi == 1'b0, "R7 bit6", mosi, 0);
    chk(($time - t0) == 16, "R11 sclk period", 32'($time - t0), 16);
    send(8'h3C); send(8'h81); send(8'h7E);
    idle(200);
    rd_chk(A_CTRL, 32'h1321, "R4 R5 after stream");
    for (int i = 0; i < 4; i++) take("R7 R9 order");
    rd_chk(A_CTRL, 32'h1121, "R5 drained");

    // R5/R6 watermark at 12 of 16
    wr(A_CTRL, RUN | IER | REN);
    for (int i = 0; i < 11; i++) send(8'(i + 1));
    idle(450);
    rd_chk(A_CTRL, 32'h1331, "R5 rxr low at 11");
    chk(irq == 1'b0, "R6 irq low at 11", irq, 0);
    send(8'd12);
    idle(60);
    rd_chk(A_CTRL, 32'h1B31, "R5 rxr at 12");
    chk(irq == 1'b1, "R6 irq at 12", irq, 1);
    for (int i = 13; i <= 16; i++) send(8'(i));
    idle(200);
    rd_chk(A_CTRL, 32'h1F31, "R5 rxf full");

    // R8 stall on full receive queue
    for (int i = 17; i <= 19; i++) send(8'(i));
    idle(200);
    rd_chk(A_CTRL, 32'h0F31, "R8 stalled");
    chk(sclk == 1'b0, "R8 sclk idle", sclk, 0);
    for (int i = 0; i < 19; i++) begin
      take("R8 R9 order after stall");
      idle(40);
    end
    rd_chk(A_CTRL, 32'h1131, "R8 drained");
    chk(irq == 1'b0, "R6 irq drop", irq, 0);

    // R3 TXD clears when full; R2 flush; R7 abort
    wr(A_DIV, 32'd0);
    wr(A_CTRL, RUN | REN);
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'h40 + i);
    rd_chk(A_CTRL, 32'h0021, "R3 txd low when full");
    wr(A_CTRL, RUN | REN | CLRTX);
    rd_chk(A_CTRL, 32'h1121, "R2 tx flush");
    wr(A_CTRL, REN);
    idle(4);
    chk(csn == 1'b1 && sclk == 1'b0, "R7 abort pins", {csn, sclk}, 2'b10);
    wr(A_DIV, 32'd4);
    wr(A_CTRL, RUN | REN);
    idle(100);
    rd_chk(A_DATA, 32'h0, "R7 aborted byte dropped");

    // R2 receive flush
    wr(A_DATA, 32'h11); wr(A_DATA, 32'h22);
    idle(100);
    rd_chk(A_CTRL, 32'h1321, "R2 before rx flush");
    wr(A_CTRL, RUN | REN | CLRRX);
    rd_chk(A_CTRL, 32'h1121, "R2 rx flush");
    rd_chk(A_DATA, 32'h0, "R2 rx empty");

    // concurrency: read every cycle while stream runs, writes mid-stream
    for (int i = 0; i < 4; i++) send(8'h90 + 8'(i));
    for (int c = 0; c < 600; c++) begin
      rd(A_DATA, v);
      if (v != 0) begin
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        chk(v == {24'h0, e}, "R7 R9 concurrent", v, {24'h0, e});
      end
      if (c == 50 || c == 150) send(8'hC0 + 8'(c));
    end
    chk(exp_q.size() == 0, "R7 all received", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule